// File: doc/BRIEF.md
# Half-Duplex Three-Wire Serial Master

This block drives a serial peripheral bus with four select lines. It can send a word or receive a word, but never both in the same frame. A host programs it through a small 16-bit register port. The host loads a word to send, sets per-select timing options and the clock dividers, and then issues one command. That command chooses a select line and starts a frame of 1 to 16 bits. The block produces the serial clock, drives the chosen select line at its programmed polarity, and shifts data in or out. Two status flags report progress: `busy` and receive-ready.

The serial clock comes from two dividers in series. The first divider is shared and can be 2, 4, 7 or 10. The second divider belongs to each select and can be 2, 4 or 8. One serial clock period is therefore D1*D2 system clocks, and each half period is D1*D2/2 clocks. Each select also has its own settings for the launch edge, the sample edge, the select polarity, and an optional wait for the peripheral to pull its data line low before the first clock edge.

The controller has four states. `ST_IDLE` goes to `ST_HOLD` when a start command arrives for a select whose ready check is on, and goes to `ST_RUN` when it is off. `ST_HOLD` goes to `ST_RUN` once the serial input is low. `ST_RUN` goes to `ST_FINISH` on the last half-period tick of the frame. `ST_FINISH` goes back to `ST_IDLE` after one cycle. In that cycle a received word is latched and the ready flag is raised.

Top module: `hdx_serial_master`

## Requirements
- R1: After reset the status register (offset 1) reads 0, the serial clock is low, and all four select lines are high. All selects reset to active-low, so high is their inactive level.
- R2: A start command that has a nonzero write count (bits 9:5) sends that many bits from the top of the data word (written at offset 0). Bit 15 goes out first.
- R3: A start command that has a write count of 0 and a nonzero read count (bits 4:0) receives that many bits. The result is right-aligned at offset 0: the last bit lands in bit 0 and the bits above the count are zero.
- R4: If both counts are nonzero, only the write frame runs, and the ready flag (status bit 15) stays 0.
- R5: The busy flag (status bit 14) is 1 from the cycle after a start until the frame ends. When a read frame ends, the ready flag is set. Reading offset 0 clears the ready flag. If a clear and a set fall in the same cycle, the set wins.
- R6: Each half period of the serial clock lasts D1*D2/2 system clocks. D1 comes from bits 2:1 of the clock register (offset 4): 0→2, 1→4, 2→7, 3→10. D2 comes from bits 4:3 of the select's setting: 0→2, 1→4, 2→8.
- R7: Outside a frame, the serial clock rests at the value of bit 0 of the invert register (offset 5). Within a select's setting, bit 1 = 1 launches data on rising edges (0 = falling), and bit 0 = 1 samples on falling edges (0 = rising).
- R8: The command register (offset 1) selects a line through bit 12 (assert) and bits 11:10 (index). Only that line goes to its active level, which is setting bit 2 (1 = high). Writing bit 12 as 0 releases all lines. The setting register at offset 2 holds select 0 in bits 5:0 and select 1 in bits 11:6. Offset 3 holds selects 2 and 3 in the same layout.
- R9: Writes to the command register while busy have no effect: no new frame starts and the select lines do not change.
- R10: If bit 0 of the clock register is 0, start commands are ignored.
- R11: When setting bit 5 is set, the frame holds the serial clock at rest until the serial input is low, and then runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears ready on offset 0) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the current offset |
| ser_clk | output | 1 | Serial clock |
| ser_out | output | 1 | Serial data to the peripheral |
| ser_in | input | 1 | Serial data from the peripheral |
| sel_line | output | 4 | Select lines, one per peripheral |

## Verification
A host read of the data register can land in the same cycle that `ST_FINISH` raises the ready flag, so one cycle both clears and sets it. The bench provokes this on every frame by holding the data-register read strobe high for the whole frame. It releases the strobe only one clock after it sees the final serial clock edge. After a read frame, the ready flag must still read 1 and the word must be intact. A second overlap also gets a directed test: a start command that arrives while a frame is running is judged by the captured bit count and by the select lines afterwards.

// File: rtl/hdx_pkg.sv
package hdx_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int WORD_W = 16;
    localparam int NUM_CS = 4;
    localparam int CFG_W  = 6;
    localparam int CNT_W  = 5;
    localparam int HALF_W = CNT_W + 1;
    localparam int DIV_W  = 4;
    localparam int IDX_W  = $clog2(NUM_CS);

    localparam logic [2:0] A_DATA   = 3'd0;
    localparam logic [2:0] A_CMD    = 3'd1;
    localparam logic [2:0] A_SETUPL = 3'd2;
    localparam logic [2:0] A_SETUPH = 3'd3;
    localparam logic [2:0] A_CLKSEL = 3'd4;
    localparam logic [2:0] A_INVERT = 3'd5;

    localparam int B_RDY   = 15;
    localparam int B_BUSY  = 14;
    localparam int B_START = 13;
    localparam int B_CSON  = 12;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HOLD,
        ST_RUN,
        ST_FINISH
    } hdx_state_e;
endpackage

// File: rtl/hdx_clkdiv.sv
module hdx_clkdiv import hdx_pkg::*; (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [1:0]       sel1,
    input  logic [1:0]       sel2,
    output logic             half_tick
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [DIV_W-1:0] lim1, lim2, c1_q, c2_q;
    logic             tick1;

    always_comb begin
        unique case (sel1)
            2'd0:    lim1 = DIV_W'(2);
            2'd1:    lim1 = DIV_W'(4);
            2'd2:    lim1 = DIV_W'(7);
            default: lim1 = DIV_W'(10);
        endcase
        // second stage counts half of its divide ratio per half period
        unique case (sel2)
            2'd0:    lim2 = DIV_W'(1);
            2'd1:    lim2 = DIV_W'(2);
            default: lim2 = DIV_W'(4);
        endcase
    end

    assign tick1     = (c1_q == lim1 - DIV_W'(1));
    assign half_tick = tick1 && (c2_q == lim2 - DIV_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c1_q <= '0;
            c2_q <= '0;
        end else if (restart) begin
            c1_q <= '0;
            c2_q <= '0;
        end else begin
            c1_q <= tick1 ? '0 : c1_q + DIV_W'(1);
            if (tick1)
                c2_q <= half_tick ? '0 : c2_q + DIV_W'(1);
        end
    end
endmodule

// File: rtl/hdx_shift_engine.sv
module hdx_shift_engine import hdx_pkg::*; (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              lead_launch,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              tx_edge,
    input  logic              rx_edge,
    input  logic              sdi,
    output logic              sdo,
    output logic [WORD_W-1:0] rx_word
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [WORD_W-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q    <= '0;
            sdo     <= 1'b0;
            rx_word <= '0;
        end else if (load) begin
            rx_word <= '0;
            if (lead_launch) begin
                sh_q <= tx_word;
                sdo  <= 1'b0;
            end else begin
                sh_q <= tx_word << 1;
                sdo  <= tx_word[WORD_W-1];
            end
        end else begin
            if (tx_edge) begin
                sdo  <= sh_q[WORD_W-1];
                sh_q <= sh_q << 1;
            end
            if (rx_edge)
                rx_word <= {rx_word[WORD_W-2:0], sdi};
        end
    end
endmodule

// File: rtl/hdx_serial_master.sv
module hdx_serial_master import hdx_pkg::*; (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              ser_clk,
    output logic              ser_out,
    input  logic              ser_in,
    output logic [NUM_CS-1:0] sel_line
);
    timeunit 1ns;
    timeprecision 1ps;

    hdx_state_e        st, st_nx;
    logic [CFG_W-1:0]  setup_q [NUM_CS];
    logic              clk_on_q, inv_q, rdy_q, cs_on_q, is_read_q;
    logic [1:0]        d1sel_q;
    logic [IDX_W-1:0]  cs_idx_q;
    logic [WORD_W-1:0] tx_q, rx_q, rx_word;
    logic [CNT_W-1:0]  nbits_q;
    logic [HALF_W-1:0] half_q, half_last;
    logic [NUM_CS-1:0] cs_pol;

    logic              busy, in_run, half_tick, go, cmd_wr, cfg_wr_ok;
    logic              tx_edge, rx_edge, rise_next, lead_launch;
    logic [CNT_W-1:0]  w_cnt, r_cnt;
    logic [IDX_W-1:0]  new_idx;
    logic [CFG_W-1:0]  cfg_new, cfg_cur;
    logic              unused_bits;

    assign w_cnt     = reg_wdata[9:5];
    assign r_cnt     = reg_wdata[4:0];
    assign new_idx   = reg_wdata[11:10];
    assign cfg_new   = setup_q[new_idx];
    assign cfg_cur   = setup_q[cs_idx_q];
    assign cmd_wr    = reg_wr && (reg_addr == A_CMD);
    assign cfg_wr_ok = reg_wr && !busy;
    assign go        = cmd_wr && (st == ST_IDLE) && reg_wdata[B_START] && clk_on_q
                       && ((w_cnt != '0) || (r_cnt != '0));
    assign half_last = {nbits_q, 1'b0} - HALF_W'(1);
    assign unused_bits = ^{reg_wdata[15:14], cfg_cur[5], cfg_cur[2], cfg_new[4:2], cfg_new[0]};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:   if (go) st_nx = cfg_new[5] ? ST_HOLD : ST_RUN;
            ST_HOLD:   if (!ser_in) st_nx = ST_RUN;
            ST_RUN:    if (half_tick && (half_q == half_last)) st_nx = ST_FINISH;
            ST_FINISH: st_nx = ST_IDLE;
            default:   st_nx = ST_IDLE;
        endcase
    end

    // state-derived outputs
    always_comb begin
        busy        = (st != ST_IDLE);
        in_run      = (st == ST_RUN);
        rise_next   = !ser_clk;
        tx_edge     = in_run && half_tick && !is_read_q && (rise_next == cfg_cur[1]);
        rx_edge     = in_run && half_tick &&  is_read_q && (rise_next != cfg_cur[0]);
        lead_launch = (cfg_new[1] == !inv_q);
    end

    hdx_clkdiv u_div (
        .clk(clk), .rst_n(rst_n), .restart(!in_run),
        .sel1(d1sel_q), .sel2(cfg_cur[4:3]), .half_tick(half_tick)
    );

    hdx_shift_engine u_shift (
        .clk(clk), .rst_n(rst_n), .load(go), .lead_launch(lead_launch),
        .tx_word(tx_q), .tx_edge(tx_edge), .rx_edge(rx_edge), .sdi(ser_in),
        .sdo(ser_out), .rx_word(rx_word)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CS; i++) setup_q[i] <= '0;
            clk_on_q  <= 1'b0;
            d1sel_q   <= '0;
            inv_q     <= 1'b0;
            tx_q      <= '0;
            rx_q      <= '0;
            rdy_q     <= 1'b0;
            cs_on_q   <= 1'b0;
            cs_idx_q  <= '0;
            is_read_q <= 1'b0;
            nbits_q   <= '0;
            half_q    <= '0;
            ser_clk   <= 1'b0;
        end else begin
            if (reg_wr && reg_addr == A_DATA) tx_q <= reg_wdata;
            if (cfg_wr_ok) begin
                for (int p = 0; p < NUM_CS / 2; p++) begin
                    if (reg_addr == A_SETUPL + 3'(p)) begin
                        setup_q[2*p]   <= reg_wdata[CFG_W-1:0];
                        setup_q[2*p+1] <= reg_wdata[2*CFG_W-1:CFG_W];
                    end
                end
                if (reg_addr == A_CLKSEL) begin
                    clk_on_q <= reg_wdata[0];
                    d1sel_q  <= reg_wdata[2:1];
                end
                if (reg_addr == A_INVERT) inv_q <= reg_wdata[0];
                if (reg_addr == A_CMD) begin
                    cs_on_q  <= reg_wdata[B_CSON];
                    cs_idx_q <= new_idx;
                end
            end
            if (go) begin
                is_read_q <= (w_cnt == '0);
                nbits_q   <= (w_cnt != '0) ? w_cnt : r_cnt;
                half_q    <= '0;
            end else if (in_run && half_tick) begin
                half_q <= half_q + HALF_W'(1);
            end
            if (in_run && half_tick) ser_clk <= !ser_clk;
            else if (st == ST_IDLE)  ser_clk <= inv_q;
            // set has priority over the read-side clear
            if (st == ST_FINISH && is_read_q) begin
                rx_q  <= rx_word;
                rdy_q <= 1'b1;
            end else if (reg_rd && reg_addr == A_DATA) begin
                rdy_q <= 1'b0;
            end
        end
    end

    for (genvar g = 0; g < NUM_CS; g++) begin : g_sel
        assign cs_pol[g]   = setup_q[g][2];
        assign sel_line[g] = (cs_on_q && cs_idx_q == IDX_W'(g)) ? cs_pol[g] : !cs_pol[g];
    end

    always_comb begin
        unique case (reg_addr)
            A_DATA:  reg_rdata = rx_q;
            A_CMD:   reg_rdata = {rdy_q, busy, 1'b0, cs_on_q, cs_idx_q, 10'b0};
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/hdx_checker.sv
module hdx_checker import hdx_pkg::*; (
    input logic              clk,
    input logic              rst_n,
    input hdx_state_e        st,
    input logic              rdy,
    input logic              sclk,
    input logic              inv,
    input logic              sdi,
    input logic              clk_on,
    input logic              wr,
    input logic [2:0]        addr,
    input logic [NUM_CS-1:0] cs,
    input logic [NUM_CS-1:0] pol
);
    timeunit 1ns;
    timeprecision 1ps;

    // R5
    rdy_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy) |-> $past(st) == ST_FINISH);

    // R7
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && $past(st) == ST_IDLE) |-> sclk == $past(inv));

    // R8
    one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~(cs ^ pol)) <= 1);

    // R9
    busy_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE && wr && addr == A_CMD) |=> $stable(cs));

    // R10
    clock_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && !clk_on && wr && addr == A_CMD) |=> st == ST_IDLE);

    // R11
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HOLD && sdi) |=> (st == ST_HOLD && $stable(sclk)));
endmodule

bind hdx_serial_master hdx_checker u_chk (
    .clk(clk), .rst_n(rst_n), .st(st), .rdy(rdy_q), .sclk(ser_clk), .inv(inv_q),
    .sdi(ser_in), .clk_on(clk_on_q), .wr(reg_wr), .addr(reg_addr),
    .cs(sel_line), .pol(cs_pol)
);

// File: tb/tb_hdx_serial_master.sv
module tb_hdx_serial_master;
    timeunit 1ns;
    timeprecision 1ps;

    typedef struct packed {
        logic [1:0]  idx;
        logic [5:0]  cfg;
        logic [1:0]  d1;
        logic        inv;
        logic [4:0]  w;
        logic [4:0]  r;
        logic [15:0] tx;
        logic [15:0] pat;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 6'b000010, 2'd0, 1'b0, 5'd8,  5'd0,  16'hA500, 16'h0000},
        '{2'd1, 6'b001001, 2'd1, 1'b0, 5'd0,  5'd12, 16'h0000, 16'h0B3C},
        '{2'd2, 6'b000100, 2'd2, 1'b1, 5'd16, 5'd0,  16'hC3A9, 16'h0000},
        '{2'd3, 6'b010111, 2'd3, 1'b1, 5'd0,  5'd16, 16'h0000, 16'hF00D},
        '{2'd0, 6'b001000, 2'd2, 1'b1, 5'd1,  5'd0,  16'h8000, 16'h0000},
        '{2'd1, 6'b000000, 2'd0, 1'b0, 5'd0,  5'd1,  16'h0000, 16'h0001},
        '{2'd2, 6'b000011, 2'd1, 1'b0, 5'd5,  5'd9,  16'h7800, 16'h01FF},
        '{2'd3, 6'b001101, 2'd0, 1'b1, 5'd0,  5'd7,  16'h0000, 16'h0055}
    };

    logic        clk = 0, rst_n = 0;
    logic [2:0]  reg_addr = 0;
    logic        reg_wr = 0, reg_rd = 0;
    logic [15:0] reg_wdata = 0, reg_rdata;
    logic        ser_clk, ser_out, ser_in;
    logic [3:0]  sel_line;

    int checks = 0, errs = 0;
    logic [3:0] pol = 4'b0;

    // peripheral model
    int m_w = 0, m_r = 0;
    logic m_wr = 0, m_rf = 0;
    logic [15:0] m_pat = 0;
    logic clr_req = 0, clr_seen = 0, prev_clk = 1'bx;
    int edge_cnt = 0, cap_n = 0, samp = 0, pres = 0;
    logic [15:0] cap = 0;
    realtime t_prev = 0, t_last = 0;
    logic ovr_en = 0, ovr_val = 0, sdi_slave;

    assign sdi_slave = (m_r != 0 && pres < m_r) ? m_pat[m_r - 1 - pres] : 1'b0;
    assign ser_in    = ovr_en ? ovr_val : sdi_slave;

    always #2.5 clk = ~clk;

    hdx_serial_master dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ser_clk(ser_clk), .ser_out(ser_out), .ser_in(ser_in), .sel_line(sel_line)
    );

    always @(ser_clk or clr_req) begin
        if (clr_req != clr_seen) begin
            clr_seen = clr_req;
            edge_cnt = 0; cap = 0; cap_n = 0; samp = 0; pres = 0;
        end else if (!$isunknown(ser_clk) && !$isunknown(prev_clk) && ser_clk != prev_clk) begin
            edge_cnt++;
            t_prev = t_last;
            t_last = $realtime;
            if (m_w != 0 && ser_clk != m_wr) begin
                cap = {cap[14:0], ser_out};
                cap_n++;
            end
            if (m_w == 0 && m_r != 0) begin
                if (ser_clk != m_rf) samp++;
                else if (samp > 0)   pres++;
            end
        end
        prev_clk = ser_clk;
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic host_wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic set_cfg(input logic [1:0] idx, input logic [5:0] cfg);
        host_wr(A_SETUPL_T + {2'b0, idx[1]}, idx[0] ? {4'b0, cfg, 6'b0} : {10'b0, cfg});
        pol[idx] = cfg[2];
        pol[idx ^ 2'd1] = 1'b0;
    endtask

    localparam logic [2:0] A_SETUPL_T = 3'd2;

    task automatic start(input logic [1:0] idx, input int w, input int r,
                         input logic [15:0] pat, input logic wr_rise, input logic rd_fall);
        m_w = w; m_r = r; m_pat = pat; m_wr = wr_rise; m_rf = rd_fall;
        clr_req = ~clr_req;
        host_wr(3'd1, {2'b00, 1'b1, 1'b1, idx, 5'(w), 5'(r)});
    endtask

    task automatic wait_edges(input int n);
        int guard = 0;
        while (edge_cnt < n && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        chk(edge_cnt >= n, "R6 edge count", edge_cnt, n);
    endtask

    task automatic wait_idle();
        int guard = 0;
        reg_addr = 3'd1;
        #1;
        while (reg_rdata[14] && guard < 20000) begin
            @(negedge clk); #1;
            guard++;
        end
    endtask

    function automatic int half_of(input logic [1:0] d1, input logic [1:0] d2);
        int a, b;
        a = (d1 == 0) ? 2 : (d1 == 1) ? 4 : (d1 == 2) ? 7 : 10;
        b = (d2 == 0) ? 2 : (d2 == 1) ? 4 : 8;
        return a * b / 2;
    endfunction

    function automatic logic [3:0] exp_cs(input logic on, input logic [1:0] idx);
        logic [3:0] e;
        for (int i = 0; i < 4; i++) e[i] = (on && idx == 2'(i)) ? pol[i] : !pol[i];
        return e;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errs++;
        $display("FAIL watchdog: actual expired expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        reg_addr = 3'd1; #1;
        // R1 reset state
        chk(reg_rdata == 16'h0, "R1 status", reg_rdata, 0);
        chk(sel_line == 4'hF, "R1 selects", sel_line, 4'hF);
        chk(ser_clk == 1'b0, "R1 sclk", ser_clk, 0);

        // R10 start ignored with module clock off
        set_cfg(2'd0, 6'b000010);
        start(2'd0, 4, 0, 16'h0, 1'b1, 1'b0);
        repeat (3) @(negedge clk);
        reg_addr = 3'd1; #1;
        chk(reg_rdata[14] == 1'b0, "R10 no busy", reg_rdata[14], 0);
        chk(edge_cnt == 0, "R10 no clock", edge_cnt, 0);

        // vector table
        for (int vi = 0; vi < NV; vi++) begin
            vec_t v;
            int n, h;
            v = VECS[vi];
            n = (v.w != 0) ? int'(v.w) : int'(v.r);
            h = half_of(v.d1, v.cfg[4:3]);
            set_cfg(v.idx, v.cfg);
            host_wr(3'd4, {13'b0, v.d1, 1'b1});
            host_wr(3'd5, {15'b0, v.inv});
            host_wr(3'd0, v.tx);
            start(v.idx, int'(v.w), int'(v.r), v.pat, v.cfg[1], v.cfg[0]);
            reg_addr = 3'd1; #1;
            chk(reg_rdata[14] == 1'b1, "R5 busy during frame", reg_rdata[14], 1);
            @(negedge clk);
            reg_addr = 3'd0; reg_rd = 1;   // read held across the end of the frame
            wait_edges(2 * n);
            @(negedge clk);
            reg_rd = 0; reg_addr = 3'd1; #1;
            chk(reg_rdata[14] == 1'b0, "R5 busy cleared", reg_rdata[14], 0);
            if (v.w != 0) begin
                chk(cap == (v.tx >> (16 - n)), "R2 sent bits", cap, v.tx >> (16 - n));
                chk(cap_n == n, "R2 bit count", cap_n, n);
                chk(reg_rdata[15] == 1'b0, "R4 no ready after write", reg_rdata[15], 0);
            end else begin
                logic [16:0] mask;
                mask = (17'h1 << n) - 17'h1;
                chk(reg_rdata[15] == 1'b1, "R5 ready wins over clear", reg_rdata[15], 1);
                reg_addr = 3'd0; #1;
                chk(reg_rdata == (v.pat & mask[15:0]), "R3 received word", reg_rdata, v.pat & mask[15:0]);
                @(negedge clk); reg_rd = 1;
                @(negedge clk); reg_rd = 0; reg_addr = 3'd1; #1;
                chk(reg_rdata[15] == 1'b0, "R5 ready cleared by read", reg_rdata[15], 0);
            end
            chk((t_last - t_prev) == h * 5.0, "R6 half period", int'((t_last - t_prev) * 10), h * 50);
            chk(ser_clk == v.inv, "R7 idle level", ser_clk, v.inv);
            chk(sel_line == exp_cs(1'b1, v.idx), "R8 select lines", sel_line, exp_cs(1'b1, v.idx));
        end

        // R8 release all selects
        host_wr(3'd1, 16'h0000);
        #1;
        chk(sel_line == exp_cs(1'b0, 2'd0), "R8 release", sel_line, exp_cs(1'b0, 2'd0));

        // R9 command while busy
        set_cfg(2'd0, 6'b000010);
        host_wr(3'd4, 16'h0007);
        host_wr(3'd5, 16'h0000);
        host_wr(3'd0, 16'h9C3E);
        start(2'd0, 16, 0, 16'h0, 1'b1, 1'b0);
        repeat (5) @(negedge clk);
        host_wr(3'd1, {2'b00, 1'b1, 1'b1, 2'd1, 5'd4, 5'd0});
        wait_idle();
        chk(cap_n == 16, "R9 frame not restarted", cap_n, 16);
        chk(cap == 16'h9C3E, "R9 data intact", cap, 16'h9C3E);
        chk(sel_line == exp_cs(1'b1, 2'd0), "R9 select unchanged", sel_line, exp_cs(1'b1, 2'd0));
        chk(reg_rdata[11:10] == 2'd0, "R9 index unchanged", reg_rdata[11:10], 0);

        // R11 ready check holds the frame
        set_cfg(2'd1, 6'b100000);
        host_wr(3'd4, 16'h0001);
        host_wr(3'd0, 16'hF000);
        ovr_en = 1; ovr_val = 1;
        start(2'd1, 4, 0, 16'h0, 1'b0, 1'b0);
        repeat (30) @(negedge clk);
        reg_addr = 3'd1; #1;
        chk(edge_cnt == 0, "R11 clock held", edge_cnt, 0);
        chk(reg_rdata[14] == 1'b1, "R11 busy while waiting", reg_rdata[14], 1);
        ovr_val = 0;
        @(negedge clk);
        wait_idle();
        chk(cap == 16'h000F && cap_n == 4, "R11 frame after release", cap, 16'h000F);
        ovr_en = 0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    end
endmodule